// File: doc/BRIEF.md
# Predicated Vector Move Sequencer

This block turns one scalar register-to-register move into a sequence of element moves whenever the source, the destination, or both are tagged as vectors. When an operand is tagged as a vector, its register number is replaced by that operand's base index. The block then walks two separate element counters, one for each side. Each counter passes over the elements that its own predicate mask turns off. Because the counters move on their own, a sparse source mask packs elements together and a sparse destination mask spreads them apart. The result is not a lane-for-lane copy.

Each cycle the sequencer does exactly one of four things. It passes over one masked-off source element, or passes over one masked-off destination element, or issues one read/write index pair, or reports completion. A register file elsewhere performs the actual transfer from `rd_idx` to `wr_idx` on every cycle that `wr_en` is high. The masks are built elsewhere and are captured when the operation starts.

Top module: `pvm_seq`

## Requirements
- R1: A `start` pulse while idle captures every operand input and raises `busy` from the next cycle. A `start` seen while `busy` is high has no effect on the running sequence.
- R2: For a vector operand, the index it issues is its base index plus its element counter, taken modulo NREG. For a scalar operand, the issued index is its own register number and never changes during the operation.
- R3: When both operands are scalar, exactly one move is issued, with `rd_idx` equal to the source register and `wr_idx` equal to the destination register. The mask inputs play no part in this case.
- R4: While the source is a vector and the source mask bit at the source counter is 0, that cycle advances the source counter by one and issues no write. Bit k of a mask belongs to element k.
- R5: The destination counter passes over a destination element whose mask bit is 0 only when the destination is a vector and the source is not passing over an element in the same cycle. At most one element is passed over per cycle.
- R6: After each issued move, each counter that belongs to a vector operand increases by one. The counter of a scalar operand stays at zero.
- R7: The sequence ends as soon as either counter reaches the vector length. `done` is then high for exactly one cycle with `wr_en` low, and `busy` is low on the next cycle.
- R8: A vector length above MAXVL is treated as MAXVL. A vector length of 0 with any vector operand finishes with no write.
- R9: An all-zero mask on a vector side finishes with no write.
- R10: After reset the block is idle, with `busy`, `wr_en` and `done` all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| vl | input | VLW | Requested vector length |
| src_vec | input | 1 | Source operand is tagged as a vector |
| dst_vec | input | 1 | Destination operand is tagged as a vector |
| src_reg | input | IDXW | Source register number as written in the move |
| dst_reg | input | IDXW | Destination register number as written in the move |
| src_base | input | IDXW | Base index used when the source is a vector |
| dst_base | input | IDXW | Base index used when the destination is a vector |
| src_mask | input | MAXVL | Source predicate, one bit per element |
| dst_mask | input | MAXVL | Destination predicate, one bit per element |
| busy | output | 1 | Operation in progress |
| rd_idx | output | IDXW | Register to read this cycle |
| wr_idx | output | IDXW | Register to write this cycle |
| wr_en | output | 1 | Move issued this cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the following. `done` never coincides with a write and is followed by idle. At most one action happens per cycle. A running sequence is never broken off by a new start. Scalar counters stay at zero, and no counter advances past the vector length. Every move on a vector source lands on a set source mask bit. Only the bench scenarios can show that the exact sequence of index pairs is right, including packing and spreading under sparse masks and index wrap past the top register. They also cover length clamping, the single move in the all-scalar case, and the fact that a start arriving mid-sequence changes none of the pairs that follow.

// File: rtl/pvm_pkg.sv
package pvm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ONE  = 2'd2,
        ST_FIN  = 2'd3
    } pvm_state_e;

    typedef enum logic [1:0] {
        ACT_END      = 2'd0,
        ACT_SKIP_SRC = 2'd1,
        ACT_SKIP_DST = 2'd2,
        ACT_MOVE     = 2'd3
    } pvm_act_e;

    typedef struct packed {
        logic load;
        logic adv_src;
        logic adv_dst;
        logic wr_en;
        logic done;
    } pvm_ctl_t;

    // Source skipping outranks destination skipping; ending outranks both.
    function automatic pvm_act_e pick_action(
        input logic ended,
        input logic s_vec,
        input logic s_bit,
        input logic d_vec,
        input logic d_bit
    );
        if (ended)               return ACT_END;
        else if (s_vec && !s_bit) return ACT_SKIP_SRC;
        else if (d_vec && !d_bit) return ACT_SKIP_DST;
        else                     return ACT_MOVE;
    endfunction

endpackage

// File: rtl/pvm_operand.sv
module pvm_operand #(
    parameter int unsigned IDXW  = 5,
    parameter int unsigned MAXVL = 16,
    parameter int unsigned CW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic             vec_in,
    input  logic [IDXW-1:0]  reg_in,
    input  logic [IDXW-1:0]  base_in,
    input  logic [MAXVL-1:0] mask_in,
    input  logic [CW-1:0]    vl_q,
    output logic             is_vec,
    output logic [IDXW-1:0]  idx_out,
    output logic             mask_bit,
    output logic             at_end
);
    localparam int unsigned MW = $clog2(MAXVL);

    logic             vec_q;
    logic [IDXW-1:0]  eff_q;
    logic [MAXVL-1:0] mask_q;
    logic [CW-1:0]    cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q  <= 1'b0;
            eff_q  <= '0;
            mask_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            vec_q  <= vec_in;
            eff_q  <= vec_in ? base_in : reg_in;
            mask_q <= mask_in;
            cnt_q  <= '0;
        end else if (adv) begin
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign is_vec   = vec_q;
    assign idx_out  = eff_q + (vec_q ? IDXW'(cnt_q) : '0);
    assign mask_bit = (cnt_q < CW'(MAXVL)) ? mask_q[cnt_q[MW-1:0]] : 1'b0;
    assign at_end   = (cnt_q >= vl_q);

    // R6: a scalar operand's counter never leaves zero
    p_scalar_cnt_r6: assert property (@(posedge clk) disable iff (rst)
        !vec_q |-> (cnt_q == '0));

    // R7: a counter only advances while still below the length
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |-> (cnt_q < vl_q));

endmodule

// File: rtl/pvm_ctrl.sv
module pvm_ctrl
    import pvm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_scalar,
    input  logic ended,
    input  logic src_vec,
    input  logic dst_vec,
    input  logic src_bit,
    input  logic dst_bit,
    output logic load,
    output logic adv_src,
    output logic adv_dst,
    output logic wr_en,
    output logic done,
    output logic busy
);
    pvm_state_e state_q, state_d;
    pvm_act_e   act;
    pvm_ctl_t   ctl;

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        act     = pick_action(ended, src_vec, src_bit, dst_vec, dst_bit);
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ctl.load = 1'b1;
                    state_d  = start_scalar ? ST_ONE : ST_RUN;
                end
            end
            ST_RUN: begin
                case (act)
                    ACT_END: begin
                        ctl.done = 1'b1;
                        state_d  = ST_IDLE;
                    end
                    ACT_SKIP_SRC: ctl.adv_src = 1'b1;
                    ACT_SKIP_DST: ctl.adv_dst = 1'b1;
                    ACT_MOVE: begin
                        ctl.wr_en   = 1'b1;
                        ctl.adv_src = src_vec;
                        ctl.adv_dst = dst_vec;
                    end
                    default: ctl = '0;
                endcase
            end
            ST_ONE: begin
                ctl.wr_en = 1'b1;
                state_d   = ST_FIN;
            end
            ST_FIN: begin
                ctl.done = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign load    = ctl.load;
    assign adv_src = ctl.adv_src;
    assign adv_dst = ctl.adv_dst;
    assign wr_en   = ctl.wr_en;
    assign done    = ctl.done;
    assign busy    = (state_q != ST_IDLE);

    // R7: completion carries no write and is followed by idle
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R5: one action per cycle at most
    p_one_action_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, adv_src && !wr_en, adv_dst && !wr_en, done}));

    // R1: a running sequence is not broken off by start
    p_busy_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
    p_write_busy_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

endmodule

// File: rtl/pvm_seq.sv
module pvm_seq #(
    parameter int unsigned NREG  = 32,
    parameter int unsigned MAXVL = 16,
    parameter int unsigned VLW   = 8,
    localparam int unsigned IDXW = $clog2(NREG),
    localparam int unsigned CW   = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VLW-1:0]   vl,
    input  logic             src_vec,
    input  logic             dst_vec,
    input  logic [IDXW-1:0]  src_reg,
    input  logic [IDXW-1:0]  dst_reg,
    input  logic [IDXW-1:0]  src_base,
    input  logic [IDXW-1:0]  dst_base,
    input  logic [MAXVL-1:0] src_mask,
    input  logic [MAXVL-1:0] dst_mask,
    output logic             busy,
    output logic [IDXW-1:0]  rd_idx,
    output logic [IDXW-1:0]  wr_idx,
    output logic             wr_en,
    output logic             done
);
    // side 0 = source, side 1 = destination
    logic [1:0]       vec_in_a, adv_a, vec_q_a, bit_a, end_a;
    logic [IDXW-1:0]  reg_a  [2];
    logic [IDXW-1:0]  base_a [2];
    logic [MAXVL-1:0] mask_a [2];
    logic [IDXW-1:0]  idx_a  [2];
    logic [CW-1:0]    vl_q, vl_clamped;
    logic             load;

    assign vl_clamped = (vl > VLW'(MAXVL)) ? CW'(MAXVL) : vl[CW-1:0];

    always_ff @(posedge clk) begin
        if (rst)       vl_q <= '0;
        else if (load) vl_q <= vl_clamped;
    end

    assign vec_in_a  = {dst_vec, src_vec};
    assign reg_a[0]  = src_reg;
    assign reg_a[1]  = dst_reg;
    assign base_a[0] = src_base;
    assign base_a[1] = dst_base;
    assign mask_a[0] = src_mask;
    assign mask_a[1] = dst_mask;

    for (genvar s = 0; s < 2; s++) begin : g_side
        pvm_operand #(.IDXW(IDXW), .MAXVL(MAXVL), .CW(CW)) u_opnd (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .adv     (adv_a[s]),
            .vec_in  (vec_in_a[s]),
            .reg_in  (reg_a[s]),
            .base_in (base_a[s]),
            .mask_in (mask_a[s]),
            .vl_q    (vl_q),
            .is_vec  (vec_q_a[s]),
            .idx_out (idx_a[s]),
            .mask_bit(bit_a[s]),
            .at_end  (end_a[s])
        );
    end

    pvm_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_scalar(!src_vec && !dst_vec),
        .ended       (end_a[0] || end_a[1]),
        .src_vec     (vec_q_a[0]),
        .dst_vec     (vec_q_a[1]),
        .src_bit     (bit_a[0]),
        .dst_bit     (bit_a[1]),
        .load        (load),
        .adv_src     (adv_a[0]),
        .adv_dst     (adv_a[1]),
        .wr_en       (wr_en),
        .done        (done),
        .busy        (busy)
    );

    assign rd_idx = idx_a[0];
    assign wr_idx = idx_a[1];

    // R4: a move from a vector source always lands on a set mask bit
    p_move_on_set_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && vec_q_a[0]) |-> bit_a[0]);

    // R5: a move into a vector destination always lands on a set mask bit
    p_dst_on_set_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && vec_q_a[1]) |-> bit_a[1]);

    // R2: a scalar source issues its fixed register while writing
    p_scalar_src_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy && $stable(busy) && !vec_q_a[0]) |-> $stable(rd_idx) || $past(load));

endmodule

// File: tb/pvm_seq_tb_top.sv
module pvm_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 32;
    localparam int MAXVL = 16;
    localparam int VLW   = 8;
    localparam int IDXW  = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [VLW-1:0]   vl = '0;
    logic             src_vec = 1'b0, dst_vec = 1'b0;
    logic [IDXW-1:0]  src_reg = '0, dst_reg = '0, src_base = '0, dst_base = '0;
    logic [MAXVL-1:0] src_mask = '0, dst_mask = '0;
    logic             busy, wr_en, done;
    logic [IDXW-1:0]  rd_idx, wr_idx;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit we;
        bit dn;
        int rd;
        int wr;
    } step_t;
    step_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pvm_seq #(.NREG(NREG), .MAXVL(MAXVL), .VLW(VLW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .vl(vl),
        .src_vec(src_vec), .dst_vec(dst_vec),
        .src_reg(src_reg), .dst_reg(dst_reg),
        .src_base(src_base), .dst_base(dst_base),
        .src_mask(src_mask), .dst_mask(dst_mask),
        .busy(busy), .rd_idx(rd_idx), .wr_idx(wr_idx),
        .wr_en(wr_en), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural model: one queue entry per cycle of the expected sequence
    task automatic build(input bit sv, input bit dv, input int sr, input int dr,
                         input int sb, input int db, input logic [MAXVL-1:0] sm,
                         input logic [MAXVL-1:0] dm, input int vreq);
        int vlen = (vreq > MAXVL) ? MAXVL : vreq;
        int i = 0;
        int j = 0;
        step_t e;
        expq.delete();
        if (!sv && !dv) begin
            e.we = 1; e.dn = 0; e.rd = sr; e.wr = dr; expq.push_back(e);
            e.we = 0; e.dn = 1; expq.push_back(e);
            return;
        end
        forever begin
            e.we = 0; e.dn = 0; e.rd = 0; e.wr = 0;
            if (i >= vlen || j >= vlen) begin
                e.dn = 1; expq.push_back(e);
                break;
            end
            if (sv && !sm[i]) i++;
            else if (dv && !dm[j]) j++;
            else begin
                e.we = 1;
                e.rd = sv ? (sb + i) % NREG : sr;
                e.wr = dv ? (db + j) % NREG : dr;
                if (sv) i++;
                if (dv) j++;
            end
            expq.push_back(e);
        end
    endtask

    task automatic run_op(input string req, input bit sv, input bit dv,
                          input int sr, input int dr, input int sb, input int db,
                          input logic [MAXVL-1:0] sm, input logic [MAXVL-1:0] dm,
                          input int vreq, input int poke);
        int k = 0;
        step_t e;
        @(negedge clk);
        src_vec = sv; dst_vec = dv;
        src_reg = IDXW'(sr); dst_reg = IDXW'(dr);
        src_base = IDXW'(sb); dst_base = IDXW'(db);
        src_mask = sm; dst_mask = dm;
        vl = VLW'(vreq);
        start = 1'b1;
        build(sv, dv, sr, dr, sb, db, sm, dm, vreq);
        @(negedge clk);
        forever begin
            e = expq.pop_front();
            chk(busy == 1'b1, req, "busy", busy, 1);
            chk(wr_en == e.we, req, "wr_en", wr_en, e.we);
            chk(done == e.dn, req, "done", done, e.dn);
            if (e.we && wr_en) begin
                chk(rd_idx == IDXW'(e.rd), req, "rd_idx", rd_idx, e.rd);
                chk(wr_idx == IDXW'(e.wr), req, "wr_idx", wr_idx, e.wr);
            end
            if (k == poke && !e.dn) begin
                // R1: a second start mid-sequence with different operands
                start = 1'b1;
                src_vec = ~sv; dst_vec = 1'b0;
                src_reg = IDXW'(sr + 3); src_base = IDXW'(sb + 7);
                src_mask = ~sm; vl = VLW'(2);
            end else begin
                start = 1'b0;
            end
            k++;
            @(negedge clk);
            if (e.dn) break;
        end
        start = 1'b0;
        chk(busy == 1'b0, req, "idle after done", busy, 0);
        chk(wr_en == 1'b0, req, "no write after done", wr_en, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lf = 32'h1ACE_B00C;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy == 1'b0, "R10", "busy", busy, 0);
        chk(wr_en == 1'b0, "R10", "wr_en", wr_en, 0);
        chk(done == 1'b0, "R10", "done", done, 0);
        rst = 1'b0;

        // R3: both scalar, masks irrelevant
        run_op("R3", 0, 0, 4, 9, 20, 21, 16'h0000, 16'h0000, 5, -1);
        // R6: both vectors, full masks
        run_op("R6", 1, 1, 0, 0, 8, 16, 16'hFFFF, 16'hFFFF, 5, -1);
        // R4: sparse source packs into dense destination
        run_op("R4", 1, 1, 0, 0, 2, 12, 16'b0000_0000_1010_0110, 16'hFFFF, 8, -1);
        // R5: dense source spreads into sparse destination
        run_op("R5", 1, 1, 0, 0, 2, 12, 16'hFFFF, 16'b0000_0000_1100_1001, 8, -1);
        // R5: both sparse, source skip takes priority
        run_op("R5", 1, 1, 0, 0, 1, 17, 16'b0000_0000_0101_0010, 16'b0000_0000_0110_0100, 7, -1);
        // R2: scalar source, vector destination wrapping past the top register
        run_op("R2", 0, 1, 6, 0, 0, 29, 16'h0000, 16'b0000_0000_0001_1011, 6, -1);
        // R2: vector source, scalar destination
        run_op("R2", 1, 0, 0, 11, 28, 0, 16'b0000_0000_0011_0101, 16'h0000, 6, -1);
        // R9: all-zero source mask, then all-zero destination mask
        run_op("R9", 1, 1, 0, 0, 3, 4, 16'h0000, 16'hFFFF, 6, -1);
        run_op("R9", 0, 1, 5, 0, 0, 4, 16'hFFFF, 16'h0000, 6, -1);
        // R8: zero length, and length above MAXVL
        run_op("R8", 1, 1, 0, 0, 3, 4, 16'hFFFF, 16'hFFFF, 0, -1);
        run_op("R8", 1, 1, 0, 0, 0, 16, 16'hFFFF, 16'hFFFF, 20, -1);
        // R7: destination runs out first
        run_op("R7", 0, 1, 2, 0, 0, 5, 16'h0000, 16'b0000_0000_0000_0111, 3, -1);
        // R1: start ignored while busy
        run_op("R1", 1, 1, 0, 0, 4, 10, 16'b0000_0000_0011_1011, 16'hFFFF, 6, 1);

        // R4 R5 R6 R7: pseudo-random mix
        for (int n = 0; n < 30; n++) begin
            logic [MAXVL-1:0] m1, m2;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            m1 = lf[15:0] | (n[0] ? lf[31:16] : 16'h0);
            lf = lf * 32'd1664525 + 32'd1013904223;
            m2 = lf[15:0] | (n[1] ? lf[31:16] : 16'h0);
            lf = lf * 32'd1664525 + 32'd1013904223;
            run_op("R6", (n % 3) != 1, (n % 3) != 2, int'(lf[4:0]), int'(lf[9:5]),
                   int'(lf[14:10]), int'(lf[19:15]), m1, m2, int'(lf[24:20]) % 19, -1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule